// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block drives the command, address and control pins of a four-bank synchronous DRAM from the moment reset is released until the memory is ready for normal traffic. First it holds the bus idle, with clock enable and data mask high, for a programmable settling time. Then it closes every bank, waits the row precharge time, and issues a programmable number of auto-refresh commands, each followed by its recovery wait. It then loads the mode register and waits the mode-set recovery time before it raises a ready flag. After that it leaves the bus idle for whatever controller follows.

The burst length, burst ordering and CAS latency come in as configuration inputs. They are packed into the address bus during the mode-register load. If the burst length or the CAS latency has no legal encoding, the sequencer never writes the mode register. It gives a one-cycle error pulse instead and parks the bus in NOP until the next reset. All waits are parameters in nanoseconds, apart from the mode-set recovery, which is in cycles. They are turned into cycle counts from a clock-period parameter.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted and for STABLE_CYC cycles after its release, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111), CKE and DQM are high, address and bank pins are zero, and init_done is low.
- R2: In the cycle after the settling period, the command is precharge-all (0010) with address bit 10 high, all other address bits zero and bank pins zero.
- R3: The first auto-refresh appears exactly RP_CYC cycles after the precharge-all, with NOP in every cycle between.
- R4: Exactly N_REF auto-refresh commands (0001) are issued, RC_CYC cycles apart, with NOP between. N_REF below 8 is rejected at elaboration.
- R5: With a legal configuration, the mode-register load (0000) appears RC_CYC cycles after the last auto-refresh.
- R6: During the mode-register load, address bits 2..0 carry the burst length code: 1 beat=000, 2=001, 4=010, 8=011.
- R7: During the mode-register load, address bit 3 carries the burst ordering: 0 sequential, 1 interleaved.
- R8: During the mode-register load, address bits 6..4 carry the CAS latency (2=010, 3=011), and address bits 11..7 and both bank pins are zero.
- R9: init_done rises RSC_CYC cycles after the mode-register load and stays high. From then on the bus carries NOP, DQM is low and CKE stays high.
- R10: If burst_len is not 1, 2, 4 or 8, or cas_lat is not 2 or 3, then no mode-register load is issued. cfg_error is high for one cycle, in the cycle where the load would have been. Afterwards the bus stays in NOP with DQM high and init_done low until reset.
- R11: Each wait in cycles is ceil(time_ns*1000/CLK_PERIOD_PS), with a floor of 2. The mode-set recovery is given directly in cycles, also with a floor of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 4 | Requested burst length in beats |
| cfg_interleave | input | 1 | Burst ordering: 1 interleaved, 0 sequential |
| cfg_cas_lat | input | 3 | Requested CAS latency in cycles |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, memory ready |
| cfg_error | output | 1 | One-cycle pulse on an illegal configuration |

## Verification
The bench sweeps all 256 combinations of the burst-length, ordering and latency inputs. For each one it compares every pin in every cycle of the sequence against a cycle schedule worked out in the bench. Off-by-one wait counters would shift the refresh or mode-load cycle and fail at once, and so would an extra or missing refresh. Wrong field placement, or letting a reserved code through, shows up in the mode word or as a missing error pulse. The timing parameters are picked so that two waits do not divide evenly, so a design that truncates instead of rounding up lands its refresh a cycle early. Running one sweep after another also covers resets out of the ready and halted states.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sdr_cmd_t;

   localparam sdr_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sdr_cmd_t CMD_PRE_ALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam sdr_cmd_t CMD_AUTOREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
   localparam sdr_cmd_t CMD_MODESET = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   typedef enum logic [3:0] {
      PH_SETTLE,
      PH_PRECHG,
      PH_WAIT_RP,
      PH_REFRESH,
      PH_WAIT_RC,
      PH_MODESET,
      PH_WAIT_RSC,
      PH_READY,
      PH_CFG_FAULT,
      PH_HALTED
   } sdr_phase_e;

   // nanoseconds to whole cycles, rounded up, never below 2
   function automatic int ns_to_cycles(input int t_ns, input int period_ps);
      int c;
      c = (t_ns * 1000 + period_ps - 1) / period_ps;
      if (c < 2) c = 2;
      return c;
   endfunction

   function automatic int floor_two(input int c);
      return (c < 2) ? 2 : c;
   endfunction

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sdr_cycle_timer.sv
module sdr_cycle_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
   parameter int AW = 12
) (
   input  logic [3:0]    burst_len,
   input  logic          interleave,
   input  logic [2:0]    cas_lat,
   output logic [AW-1:0] word,
   output logic          legal
);

   logic [2:0] bl_code;
   logic       bl_ok;
   logic [2:0] cl_code;
   logic       cl_ok;
   logic [6:0] low_word;

   always_comb begin
      bl_ok = 1'b1;
      unique case (burst_len)
         4'd1:    bl_code = 3'b000;
         4'd2:    bl_code = 3'b001;
         4'd4:    bl_code = 3'b010;
         4'd8:    bl_code = 3'b011;
         default: begin
            bl_code = 3'b000;
            bl_ok   = 1'b0;
         end
      endcase
   end

   always_comb begin
      cl_ok = 1'b1;
      unique case (cas_lat)
         3'd2:    cl_code = 3'b010;
         3'd3:    cl_code = 3'b011;
         default: begin
            cl_code = 3'b000;
            cl_ok   = 1'b0;
         end
      endcase
   end

   assign low_word = {cl_code, interleave, bl_code};
   assign legal    = bl_ok && cl_ok;

   generate
      if (AW > 7) begin : g_pad
         assign word = {{(AW-7){1'b0}}, low_word};
      end else begin : g_bad_width
         $error("sdr_mode_word: AW must exceed 7");
         assign word = '0;
      end
   endgenerate

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
   import sdr_init_pkg::*;
#(
   parameter int SETTLE_CYC = 125000,
   parameter int RP_CYC     = 5,
   parameter int RC_CYC     = 18,
   parameter int RSC_CYC    = 2,
   parameter int N_REF      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_legal,
   output sdr_phase_e phase,
   output sdr_cmd_t   cmd,
   output logic       init_done,
   output logic       cfg_error
);

   localparam int MAXC = max_of3(SETTLE_CYC, RP_CYC, max_of3(RC_CYC, RSC_CYC, 2));
   localparam int TW   = $clog2(MAXC + 1);
   localparam int RW   = $clog2(N_REF + 1);

   sdr_phase_e ph_q, ph_d;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_exp;
   logic          ref_step;
   logic          ref_exp;

   sdr_cycle_timer #(.W(TW), .RST_VAL(SETTLE_CYC - 1)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .step     (1'b1),
      .expired  (tmr_exp)
   );

   sdr_cycle_timer #(.W(RW), .RST_VAL(N_REF - 1)) u_refs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (1'b0),
      .load_val ('0),
      .step     (ref_step),
      .expired  (ref_exp)
   );

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_step = 1'b0;
      unique case (ph_q)
         PH_SETTLE:   if (tmr_exp) ph_d = PH_PRECHG;
         PH_PRECHG: begin
            ph_d     = PH_WAIT_RP;
            tmr_load = 1'b1;
            tmr_val  = TW'(RP_CYC - 2);
         end
         PH_WAIT_RP:  if (tmr_exp) ph_d = PH_REFRESH;
         PH_REFRESH: begin
            ph_d     = PH_WAIT_RC;
            tmr_load = 1'b1;
            tmr_val  = TW'(RC_CYC - 2);
         end
         PH_WAIT_RC: begin
            if (tmr_exp) begin
               if (!ref_exp) begin
                  ph_d     = PH_REFRESH;
                  ref_step = 1'b1;
               end else if (mode_legal) begin
                  ph_d = PH_MODESET;
               end else begin
                  ph_d = PH_CFG_FAULT;
               end
            end
         end
         PH_MODESET: begin
            ph_d     = PH_WAIT_RSC;
            tmr_load = 1'b1;
            tmr_val  = TW'(RSC_CYC - 2);
         end
         PH_WAIT_RSC: if (tmr_exp) ph_d = PH_READY;
         PH_READY:     ph_d = PH_READY;
         PH_CFG_FAULT: ph_d = PH_HALTED;
         PH_HALTED:    ph_d = PH_HALTED;
         default:      ph_d = PH_HALTED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_SETTLE;
      else        ph_q <= ph_d;
   end

   always_comb begin
      unique case (ph_q)
         PH_PRECHG:  cmd = CMD_PRE_ALL;
         PH_REFRESH: cmd = CMD_AUTOREF;
         PH_MODESET: cmd = CMD_MODESET;
         default:    cmd = CMD_NOP;
      endcase
   end

   assign phase     = ph_q;
   assign init_done = (ph_q == PH_READY);
   assign cfg_error = (ph_q == PH_CFG_FAULT);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdr_init_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int T_SETTLE_NS   = 500000,
   parameter int T_RP_NS       = 20,
   parameter int T_RC_NS       = 70,
   parameter int T_RSC_CYC     = 2,
   parameter int N_REF         = 8,
   parameter int ADDR_W        = 12,
   parameter int BANK_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cfg_burst_len,
   input  logic              cfg_interleave,
   input  logic [2:0]        cfg_cas_lat,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic              sd_dqm,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_done,
   output logic              cfg_error
);

   localparam int SETTLE_CYC = ns_to_cycles(T_SETTLE_NS, CLK_PERIOD_PS);
   localparam int RP_CYC     = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
   localparam int RC_CYC     = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
   localparam int RSC_CYC    = floor_two(T_RSC_CYC);
   localparam int ALLBANK_BIT = 10;

   generate
      if (N_REF < 8) begin : g_bad_nref
         $error("sdram_pwrup_seq: N_REF must be at least 8");
      end
      if (ADDR_W < 11) begin : g_bad_aw
         $error("sdram_pwrup_seq: ADDR_W must be at least 11");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("sdram_pwrup_seq: CLK_PERIOD_PS must be positive");
      end
   endgenerate

   sdr_phase_e        phase;
   sdr_cmd_t          cmd;
   logic [ADDR_W-1:0] mode_word;
   logic              mode_legal;

   sdr_mode_word #(.AW(ADDR_W)) u_mode (
      .burst_len  (cfg_burst_len),
      .interleave (cfg_interleave),
      .cas_lat    (cfg_cas_lat),
      .word       (mode_word),
      .legal      (mode_legal)
   );

   sdr_init_fsm #(
      .SETTLE_CYC (SETTLE_CYC),
      .RP_CYC     (RP_CYC),
      .RC_CYC     (RC_CYC),
      .RSC_CYC    (RSC_CYC),
      .N_REF      (N_REF)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_legal (mode_legal),
      .phase      (phase),
      .cmd        (cmd),
      .init_done  (init_done),
      .cfg_error  (cfg_error)
   );

   always_comb begin
      sd_addr = '0;
      if (phase == PH_PRECHG)       sd_addr[ALLBANK_BIT] = 1'b1;
      else if (phase == PH_MODESET) sd_addr = mode_word;
   end

   assign sd_ba    = '0;
   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;
   assign sd_cke   = 1'b1;
   assign sd_dqm   = !init_done;

endmodule

// File: rtl/sdr_init_checker.sv
module sdr_init_checker #(
   parameter int RP_CYC = 5,
   parameter int RC_CYC = 18,
   parameter int AW     = 12,
   parameter int BW     = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sd_cs_n,
   input logic          sd_ras_n,
   input logic          sd_cas_n,
   input logic          sd_we_n,
   input logic          sd_cke,
   input logic          sd_dqm,
   input logic [BW-1:0] sd_ba,
   input logic [AW-1:0] sd_addr,
   input logic          init_done,
   input logic          cfg_error
);

   logic [3:0]  cmd;
   logic [3:0]  last_cmd_q;
   logic [15:0] gap_q;
   logic        fault_seen_q;

   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_cmd_q   <= 4'b0111;
         gap_q        <= '0;
         fault_seen_q <= 1'b0;
      end else begin
         if (cmd != 4'b0111) begin
            last_cmd_q <= cmd;
            gap_q      <= 16'd1;
         end else if (gap_q != 16'hffff) begin
            gap_q <= gap_q + 16'd1;
         end
         if (cfg_error) fault_seen_q <= 1'b1;
      end
   end

   AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cke) else $error("cke low"); // R1
   AST_DQM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> sd_dqm) else $error("dqm low early"); // R1
   AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0)) else $error("precharge not all-bank"); // R2
   AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 4'b0111 && last_cmd_q == 4'b0010) |-> (gap_q == 16'(RP_CYC))) else $error("trp gap"); // R3
   AST_TRC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 4'b0111 && last_cmd_q == 4'b0001) |-> (gap_q == 16'(RC_CYC))) else $error("trc gap"); // R4
   AST_MODE_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000) |-> !sd_addr[2]) else $error("reserved burst code"); // R6
   AST_MODE_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000) |-> (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011)) else $error("reserved latency code"); // R8
   AST_MODE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0000) |-> (sd_addr[AW-1:7] == '0 && sd_ba == '0)) else $error("mode high bits set"); // R8
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done) else $error("done dropped"); // R9
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == 4'b0111 && !sd_dqm)) else $error("bus busy after done"); // R9
   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> !cfg_error) else $error("error not a pulse"); // R10
   AST_FAULT_NO_MODESET: assert property (@(posedge clk) disable iff (!rst_n)
      fault_seen_q |-> (cmd == 4'b0111 && !init_done)) else $error("activity after fault"); // R10

endmodule

bind sdram_pwrup_seq sdr_init_checker #(
   .RP_CYC (RP_CYC),
   .RC_CYC (RC_CYC),
   .AW     (ADDR_W),
   .BW     (BANK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_cke    (sd_cke),
   .sd_dqm    (sd_dqm),
   .sd_ba     (sd_ba),
   .sd_addr   (sd_addr),
   .init_done (init_done),
   .cfg_error (cfg_error)
);

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;

   localparam int PER_PS = 4000;
   localparam int SET_NS = 200;
   localparam int RP_NS  = 18;
   localparam int RC_NS  = 58;
   localparam int RSC    = 3;
   localparam int NREF   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bl = 4'd1;
   logic        il = 1'b0;
   logic [2:0]  cl = 3'd2;
   logic        cs_n, ras_n, cas_n, we_n, cke, dqm, done, err;
   logic [1:0]  ba;
   logic [11:0] addr;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sdram_pwrup_seq #(
      .CLK_PERIOD_PS (PER_PS),
      .T_SETTLE_NS   (SET_NS),
      .T_RP_NS       (RP_NS),
      .T_RC_NS       (RC_NS),
      .T_RSC_CYC     (RSC),
      .N_REF         (NREF)
   ) u0 (
      .clk (clk), .rst_n (rst_n),
      .cfg_burst_len (bl), .cfg_interleave (il), .cfg_cas_lat (cl),
      .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n), .sd_we_n (we_n),
      .sd_cke (cke), .sd_dqm (dqm), .sd_ba (ba), .sd_addr (addr),
      .init_done (done), .cfg_error (err)
   );

   // R11: independent ceiling arithmetic
   function automatic int to_cyc(input int ns);
      int c;
      c = ns * 1000 / PER_PS;
      if (c * PER_PS < ns * 1000) c = c + 1;
      if (c < 2) c = 2;
      return c;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      int d, rp, rc, t_ref0, t_mrs, t_done;
      d  = to_cyc(SET_NS);
      rp = to_cyc(RP_NS);
      rc = to_cyc(RC_NS);
      t_ref0 = d + rp;
      t_mrs  = t_ref0 + NREF * rc;
      t_done = t_mrs + RSC;
      for (int run = 0; run < 256; run++) begin
         logic [3:0] cbl;
         logic       cil;
         logic [2:0] ccl;
         bit         valid;
         logic [11:0] word;
         cbl = run[3:0];
         cil = run[4];
         ccl = run[7:5];
         @(negedge clk);
         rst_n = 1'b0;
         bl = cbl; il = cil; cl = ccl;
         repeat (2) @(negedge clk);
         // R1: reset state
         check("R1 reset", {20'd0, cs_n, ras_n, cas_n, we_n, cke, dqm, done, err, addr == 12'd0, ba == 2'd0, 2'b00},
               {20'd0, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00});
         rst_n = 1'b1;
         valid = (cbl == 1 || cbl == 2 || cbl == 4 || cbl == 8) && (ccl == 2 || ccl == 3);
         word = 12'd0;
         if (valid) word = (12'(ccl) << 4) | (12'(cil) << 3) | 12'($clog2(int'(cbl)));
         for (int k = 0; k <= t_done + 3; k++) begin
            logic [3:0]  ecmd;
            logic [11:0] eaddr;
            logic        edone, eerr;
            string       tag;
            ecmd = 4'b0111; eaddr = 12'd0; eerr = 1'b0;
            edone = valid && (k >= t_done);
            if (k < d) tag = "R1";
            else if (k == d) begin tag = "R2"; ecmd = 4'b0010; eaddr = 12'h400; end
            else if (k < t_ref0) tag = "R3";
            else if (k < t_mrs) begin
               tag = (k == t_ref0) ? "R3 R11" : "R4";
               if ((k - t_ref0) % rc == 0) ecmd = 4'b0001;
            end else if (k == t_mrs) begin
               if (valid) begin tag = "R5"; ecmd = 4'b0000; eaddr = word; end
               else begin tag = "R10"; eerr = 1'b1; end
            end else tag = valid ? "R9" : "R10";
            check(tag, {14'd0, cs_n, ras_n, cas_n, we_n, addr, ba},
                  {14'd0, ecmd, eaddr, 2'b00});
            check(tag, {28'd0, cke, dqm, done, err}, {28'd0, 1'b1, !edone, edone, eerr});
            if (k == t_mrs && valid) begin
               check("R6", {29'd0, addr[2:0]}, {29'd0, 3'($clog2(int'(cbl)))});
               check("R7", {31'd0, addr[3]}, {31'd0, cil});
               check("R8", {24'd0, addr[11:4]}, {24'd0, 5'd0, ccl});
            end
            @(negedge clk);
         end
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule